// File: doc/BRIEF.md
# Memory-Mapped Packet FIFO Controller

This peripheral sits between a processor's 32-bit register port and a packet stream link. For transmit, software pushes 32-bit words one at a time into a single data address. It then writes the packet's byte length to a length address. That write commits the pushed words as one packet, and the block sends them on an outbound valid/ready stream. The last word carries a last flag and a byte-enable mask.

For receive, inbound stream words are stored in a data FIFO. When a packet's last word arrives, its byte length is stored in a separate length queue. Software reads a length first and then drains the words from a single data address.

Each direction has a reset that takes effect only for a key value. A shared link reset clears both directions. An interrupt status register, an enable register and an interrupt output report completions, resets and access errors.

Top module: `mm_pkt_fifo`

## Requirements
- R1: After reset the registers read as follows: status 0, enable 0, TX vacancy DATA_DEPTH (32), RX occupancy 0. After reset `irq` and `txValid` are 0 and `rxReady` is 1.
- R2: Each write to word 4 (TX data) appends one word and lowers TX vacancy (word 3, bits 8:0) by one. A write while the TX FIFO is full is dropped and sets status bit 28.
- R3: A write to word 5 (TX length, bits 10:0 = bytes) commits the packet when its length is nonzero and ceil(len/4) equals the number of words written since the last commit or drop. The outbound stream then emits those words in order, with `txLast` on the final word. `txKeep` is 4'b1111 on every word except the final one, where it is 1111/0001/0011/0111 for len%4 = 0/1/2/3.
- R4: Status bit 27 (TX complete) is set on the cycle after the final word of a packet is accepted.
- R5: A TX length write that is zero or does not match the pending word count sets status bit 25, discards the pending words (vacancy is restored) and sends nothing.
- R6: Inbound words are accepted while `rxReady` is high. On the `rxLast` word, the byte length 4*(words-1)+ones(`rxKeep`) is queued and status bit 26 (RX complete) is set. `rxKeep` is contiguous from bit 0.
- R7: RX occupancy (word 7, bits 8:0) counts the stored words, and TX vacancy counts the free words. All upper bits of both read as 0.
- R8: A read of word 9 returns the oldest queued RX length in bits 10:0 and pops it. A read of word 8 returns the oldest stored word and pops it. Packets come out in arrival order.
- R9: A read of word 8 with no stored word returns 0 and sets status bit 31. A read of word 9 with no queued length returns 0 and sets status bit 29.
- R10: Writing exactly 0x000000A5 has the following effects: to word 2 it clears the TX side and sets bit 24; to word 6 it clears the RX side and sets bit 23; to word 10 it does both. Any other value written to these words is ignored.
- R11: Writing 1 to a status bit clears that bit, and bits written 0 are kept. Enable bits 31:23 are read/write and all other enable bits read as 0. `irq` is high whenever a status bit and its enable bit are both 1.
- R12: While `txValid` is high and `txReady` is low, `txData`, `txLast` and `txKeep` hold their values.
- R13: `rxReady` is low once the RX FIFO holds DATA_DEPTH words. No FIFO count ever exceeds its depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWordAddr | input | 4 | Register word index (byte offset / 4) |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops for words 8 and 9) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the cycle of the strobe |
| irq | output | 1 | Interrupt request |
| txValid | output | 1 | Outbound word valid |
| txReady | input | 1 | Outbound sink ready |
| txData | output | 32 | Outbound word |
| txLast | output | 1 | Final word of packet |
| txKeep | output | 4 | Byte enables of outbound word |
| rxValid | input | 1 | Inbound word valid |
| rxReady | output | 1 | Block can accept an inbound word |
| rxData | input | 32 | Inbound word |
| rxLast | input | 1 | Final word of inbound packet |
| rxKeep | input | 4 | Byte enables of inbound final word |

## Verification
The assertions assume that a register read and a register write never arrive in the same cycle. They also assume that `rxKeep` on a final word is contiguous from bit 0 and that no inbound packet exceeds 2047 bytes. The bench issues each register access in a cycle of its own with the other strobe low. It sends only short packets whose final mask is one of 0001, 0011 or 1111, and it changes `txReady` only at falling edges.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  // register word indices
  localparam logic [3:0] IDX_ISR     = 4'd0;
  localparam logic [3:0] IDX_IER     = 4'd1;
  localparam logic [3:0] IDX_TXRST   = 4'd2;
  localparam logic [3:0] IDX_TXVAC   = 4'd3;
  localparam logic [3:0] IDX_TXDATA  = 4'd4;
  localparam logic [3:0] IDX_TXLEN   = 4'd5;
  localparam logic [3:0] IDX_RXRST   = 4'd6;
  localparam logic [3:0] IDX_RXOCC   = 4'd7;
  localparam logic [3:0] IDX_RXDATA  = 4'd8;
  localparam logic [3:0] IDX_RXLEN   = 4'd9;
  localparam logic [3:0] IDX_LINKRST = 4'd10;

  // status bit positions
  localparam int BIT_RX_UREAD  = 31;
  localparam int BIT_RX_OREAD  = 30;
  localparam int BIT_RX_ULEN   = 29;
  localparam int BIT_TX_OVR    = 28;
  localparam int BIT_TX_DONE   = 27;
  localparam int BIT_RX_DONE   = 26;
  localparam int BIT_TX_SIZE   = 25;
  localparam int BIT_TX_RSTOK  = 24;
  localparam int BIT_RX_RSTOK  = 23;

  localparam logic [31:0] STATUS_MASK = 32'hFF80_0000;
  localparam logic [31:0] CLEAR_KEY   = 32'h0000_00A5;

  localparam int LEN_W = 11;
  localparam int WCNT_W = 10;

  typedef struct packed {
    logic txPush;
    logic txCommit;
    logic txDrop;
    logic txClear;
    logic rxPopData;
    logic rxPopLen;
    logic rxClear;
  } mpf_strobe_t;
endpackage

// File: rtl/mpf_queue.sv
module mpf_queue #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  input  logic [CW-1:0]    dropCnt,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wPtr, rPtr;
  logic pushOk, popOk;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign pushOk = push && !full;
  assign popOk  = pop && !empty;
  assign headData = mem[rPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wPtr  <= '0;
      rPtr  <= '0;
      count <= '0;
    end else if (clear) begin
      wPtr  <= '0;
      rPtr  <= '0;
      count <= '0;
    end else begin
      wPtr  <= wPtr + AW'(pushOk) - dropCnt[AW-1:0];
      rPtr  <= rPtr + AW'(popOk);
      count <= count + CW'(pushOk) - CW'(popOk) - dropCnt;
    end
  end

  assert_count_bound_R13: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
endmodule

// File: rtl/mpf_datapath.sv
module mpf_datapath
  import mpf_pkg::*;
#(
  parameter int DATA_DEPTH = 32,
  parameter int LEN_DEPTH  = 8,
  localparam int DCW = $clog2(DATA_DEPTH) + 1,
  localparam int LCW = $clog2(LEN_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mpf_strobe_t       strb,
  input  logic [31:0]       wrData,
  output logic              txValid,
  input  logic              txReady,
  output logic [31:0]       txData,
  output logic              txLast,
  output logic [3:0]        txKeep,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [31:0]       rxData,
  input  logic              rxLast,
  input  logic [3:0]        rxKeep,
  output logic              txFull,
  output logic              txLenFull,
  output logic [WCNT_W-1:0] txPend,
  output logic [8:0]        txVacancy,
  output logic [8:0]        rxOccupancy,
  output logic [31:0]       rxWord,
  output logic [LEN_W-1:0]  rxLen,
  output logic              rxEmpty,
  output logic              rxLenEmpty,
  output logic              txDoneEvt,
  output logic              rxDoneEvt
);
  logic [DCW-1:0] txCount, rxCount, txDropCnt;
  logic [LCW-1:0] txLenCount, rxLenCount;
  logic txLenEmpty, rxFull, rxLenFull, txFire, rxFire;
  logic [LEN_W-1:0] txLenHead, rxByteAcc, rxLenIn;
  logic [11:0] headRound;
  logic [WCNT_W-1:0] headWords, sentCnt;
  logic [2:0] keepBytes;

  // ---------------- transmit ----------------
  assign txDropCnt = strb.txDrop ? DCW'(txPend) : '0;

  mpf_queue #(.WIDTH(32), .DEPTH(DATA_DEPTH)) u_txData (
    .clk, .rstN, .clear(strb.txClear), .push(strb.txPush), .pushData(wrData),
    .pop(txFire), .dropCnt(txDropCnt), .headData(txData), .count(txCount),
    .full(txFull), .empty());

  mpf_queue #(.WIDTH(LEN_W), .DEPTH(LEN_DEPTH)) u_txLen (
    .clk, .rstN, .clear(strb.txClear), .push(strb.txCommit),
    .pushData(wrData[LEN_W-1:0]), .pop(txFire && txLast), .dropCnt('0),
    .headData(txLenHead), .count(txLenCount), .full(txLenFull),
    .empty(txLenEmpty));

  assign headRound = {1'b0, txLenHead} + 12'd3;
  assign headWords = headRound[11:2];
  assign txValid   = !txLenEmpty;
  assign txLast    = (sentCnt == headWords - 1'b1);
  assign txFire    = txValid && txReady;
  assign txDoneEvt = txFire && txLast;

  always_comb begin
    txKeep = 4'b1111;
    if (txLast) begin
      case (txLenHead[1:0])
        2'd1:    txKeep = 4'b0001;
        2'd2:    txKeep = 4'b0011;
        2'd3:    txKeep = 4'b0111;
        default: txKeep = 4'b1111;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPend  <= '0;
      sentCnt <= '0;
    end else if (strb.txClear) begin
      txPend  <= '0;
      sentCnt <= '0;
    end else begin
      if (strb.txCommit || strb.txDrop) txPend <= '0;
      else if (strb.txPush && !txFull) txPend <= txPend + 1'b1;
      if (txFire) sentCnt <= txLast ? '0 : sentCnt + 1'b1;
    end
  end

  assign txVacancy = 9'(DATA_DEPTH) - 9'(txCount);

  // ---------------- receive ----------------
  assign rxReady   = !rxFull && !rxLenFull;
  assign rxFire    = rxValid && rxReady;
  assign keepBytes = 3'(rxKeep[0]) + 3'(rxKeep[1]) + 3'(rxKeep[2]) + 3'(rxKeep[3]);
  assign rxLenIn   = rxByteAcc + LEN_W'(keepBytes);
  assign rxDoneEvt = rxFire && rxLast;

  mpf_queue #(.WIDTH(32), .DEPTH(DATA_DEPTH)) u_rxData (
    .clk, .rstN, .clear(strb.rxClear), .push(rxFire), .pushData(rxData),
    .pop(strb.rxPopData), .dropCnt('0), .headData(rxWord), .count(rxCount),
    .full(rxFull), .empty(rxEmpty));

  mpf_queue #(.WIDTH(LEN_W), .DEPTH(LEN_DEPTH)) u_rxLen (
    .clk, .rstN, .clear(strb.rxClear), .push(rxDoneEvt), .pushData(rxLenIn),
    .pop(strb.rxPopLen), .dropCnt('0), .headData(rxLen), .count(rxLenCount),
    .full(rxLenFull), .empty(rxLenEmpty));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxByteAcc <= '0;
    else if (strb.rxClear) rxByteAcc <= '0;
    else if (rxFire) rxByteAcc <= rxLast ? '0 : rxByteAcc + LEN_W'(4);
  end

  assign rxOccupancy = 9'(rxCount);

  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !strb.txClear) |=>
      (txValid && $stable(txData) && $stable(txLast) && $stable(txKeep)));

  assert_rx_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady && rxLast && !strb.rxClear && !strb.rxPopLen) |=>
      (rxLenCount == $past(rxLenCount) + 1'b1));
endmodule

// File: rtl/mpf_ctrl.sv
module mpf_ctrl
  import mpf_pkg::*;
#(
  parameter int DATA_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regWordAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq,
  output mpf_strobe_t       strb,
  input  logic              txFull,
  input  logic              txLenFull,
  input  logic [WCNT_W-1:0] txPend,
  input  logic [8:0]        txVacancy,
  input  logic [8:0]        rxOccupancy,
  input  logic [31:0]       rxWord,
  input  logic [LEN_W-1:0]  rxLen,
  input  logic              rxEmpty,
  input  logic              rxLenEmpty,
  input  logic              txDoneEvt,
  input  logic              rxDoneEvt
);
  logic [31:0] isrQ, ierQ, setVec, clrVec;
  logic wrLen, isKey, lenOk;
  logic [11:0] lenRound;
  logic [WCNT_W-1:0] lenWords;

  assign isKey    = (regWdata == CLEAR_KEY);
  assign wrLen    = regWr && (regWordAddr == IDX_TXLEN);
  assign lenRound = {1'b0, regWdata[LEN_W-1:0]} + 12'd3;
  assign lenWords = lenRound[11:2];
  assign lenOk    = (regWdata[LEN_W-1:0] != '0) && (lenWords == txPend);

  always_comb begin
    strb           = '0;
    strb.txPush    = regWr && (regWordAddr == IDX_TXDATA);
    strb.txCommit  = wrLen && lenOk && !txLenFull;
    strb.txDrop    = wrLen && !(lenOk && !txLenFull);
    strb.txClear   = regWr && isKey &&
                     (regWordAddr == IDX_TXRST || regWordAddr == IDX_LINKRST);
    strb.rxClear   = regWr && isKey &&
                     (regWordAddr == IDX_RXRST || regWordAddr == IDX_LINKRST);
    strb.rxPopData = regRd && (regWordAddr == IDX_RXDATA);
    strb.rxPopLen  = regRd && (regWordAddr == IDX_RXLEN);
  end

  always_comb begin
    setVec = '0;
    setVec[BIT_RX_UREAD] = strb.rxPopData && rxEmpty;
    setVec[BIT_RX_ULEN]  = strb.rxPopLen && rxLenEmpty;
    setVec[BIT_TX_OVR]   = (strb.txPush && txFull) || (wrLen && lenOk && txLenFull);
    setVec[BIT_TX_DONE]  = txDoneEvt;
    setVec[BIT_RX_DONE]  = rxDoneEvt;
    setVec[BIT_TX_SIZE]  = wrLen && !lenOk;
    setVec[BIT_TX_RSTOK] = strb.txClear;
    setVec[BIT_RX_RSTOK] = strb.rxClear;
    clrVec = (regWr && regWordAddr == IDX_ISR) ? regWdata : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isrQ <= '0;
      ierQ <= '0;
    end else begin
      isrQ <= ((isrQ & ~clrVec) | setVec) & STATUS_MASK;
      if (regWr && regWordAddr == IDX_IER) ierQ <= regWdata & STATUS_MASK;
    end
  end

  assign irq = |(isrQ & ierQ);

  always_comb begin
    case (regWordAddr)
      IDX_ISR:    regRdata = isrQ;
      IDX_IER:    regRdata = ierQ;
      IDX_TXVAC:  regRdata = {23'd0, txVacancy};
      IDX_RXOCC:  regRdata = {23'd0, rxOccupancy};
      IDX_RXDATA: regRdata = rxEmpty ? '0 : rxWord;
      IDX_RXLEN:  regRdata = rxLenEmpty ? '0 : {21'd0, rxLen};
      default:    regRdata = '0;
    endcase
  end

  assert_uread_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regWordAddr == IDX_RXDATA && rxEmpty) |=> isrQ[BIT_RX_UREAD]);

  assert_txkey_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regWordAddr == IDX_TXRST && regWdata == CLEAR_KEY) |=>
      (isrQ[BIT_TX_RSTOK] && txVacancy == 9'(DATA_DEPTH)));

  assert_txdone_R4: assert property (@(posedge clk) disable iff (!rstN)
    txDoneEvt |=> isrQ[BIT_TX_DONE]);

  assert_size_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrLen && lenWords != txPend) |=> (isrQ[BIT_TX_SIZE] && txPend == '0));

  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rstN)
    (isrQ[22:0] == '0) && (ierQ[22:0] == '0));
endmodule

// File: rtl/mm_pkt_fifo.sv
module mm_pkt_fifo
  import mpf_pkg::*;
#(
  parameter int DATA_DEPTH = 32,
  parameter int LEN_DEPTH  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regWordAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        irq,
  output logic        txValid,
  input  logic        txReady,
  output logic [31:0] txData,
  output logic        txLast,
  output logic [3:0]  txKeep,
  input  logic        rxValid,
  output logic        rxReady,
  input  logic [31:0] rxData,
  input  logic        rxLast,
  input  logic [3:0]  rxKeep
);
  mpf_strobe_t strb;
  logic txFull, txLenFull, rxEmpty, rxLenEmpty, txDoneEvt, rxDoneEvt;
  logic [WCNT_W-1:0] txPend;
  logic [8:0] txVacancy, rxOccupancy;
  logic [31:0] rxWord;
  logic [LEN_W-1:0] rxLen;

  mpf_ctrl #(.DATA_DEPTH(DATA_DEPTH)) u_ctrl (
    .clk, .rstN, .regWordAddr, .regWr, .regRd, .regWdata, .regRdata, .irq,
    .strb, .txFull, .txLenFull, .txPend, .txVacancy, .rxOccupancy, .rxWord,
    .rxLen, .rxEmpty, .rxLenEmpty, .txDoneEvt, .rxDoneEvt);

  mpf_datapath #(.DATA_DEPTH(DATA_DEPTH), .LEN_DEPTH(LEN_DEPTH)) u_data (
    .clk, .rstN, .strb, .wrData(regWdata), .txValid, .txReady, .txData,
    .txLast, .txKeep, .rxValid, .rxReady, .rxData, .rxLast, .rxKeep,
    .txFull, .txLenFull, .txPend, .txVacancy, .rxOccupancy, .rxWord, .rxLen,
    .rxEmpty, .rxLenEmpty, .txDoneEvt, .rxDoneEvt);
endmodule

// File: tb/mm_pkt_fifo_bench.sv
`timescale 1ns/1ps
module mm_pkt_fifo_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic [3:0] regWordAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic irq, txValid, txLast, rxReady;
  logic txReady = 1'b0;
  logic [31:0] txData;
  logic [3:0] txKeep;
  logic rxValid = 1'b0, rxLast = 1'b0;
  logic [31:0] rxData = '0;
  logic [3:0] rxKeep = 4'b1111;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  mm_pkt_fifo u_mm_pkt_fifo (.*);

  typedef struct packed {
    logic        isWr;
    logic [3:0]  idx;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0,  32'h0, 32'h0},          // R1 status
    '{1'b0, 4'd1,  32'h0, 32'h0},          // R1 enable
    '{1'b0, 4'd3,  32'h0, 32'd32},         // R1 R7 vacancy
    '{1'b0, 4'd7,  32'h0, 32'd0},          // R7 occupancy
    '{1'b1, 4'd1,  32'hFFFF_FFFF, 32'h0},
    '{1'b0, 4'd1,  32'h0, 32'hFF80_0000},  // R11 enable mask
    '{1'b1, 4'd1,  32'h0, 32'h0},
    '{1'b1, 4'd2,  32'h5A, 32'h0},         // R10 wrong key
    '{1'b0, 4'd0,  32'h0, 32'h0},          // R10 ignored
    '{1'b1, 4'd2,  32'hA5, 32'h0},
    '{1'b0, 4'd0,  32'h0, 32'h0100_0000},  // R10 tx reset done
    '{1'b1, 4'd0,  32'h0100_0000, 32'h0},  // R11 W1C
    '{1'b0, 4'd0,  32'h0, 32'h0},          // R11
    '{1'b0, 4'd8,  32'h0, 32'h0},          // R9 empty data read
    '{1'b0, 4'd0,  32'h0, 32'h8000_0000},  // R9
    '{1'b0, 4'd9,  32'h0, 32'h0},          // R9 empty length read
    '{1'b0, 4'd0,  32'h0, 32'hA000_0000},  // R9
    '{1'b1, 4'd0,  32'h8000_0000, 32'h0},
    '{1'b0, 4'd0,  32'h0, 32'h2000_0000},  // R11 partial clear
    '{1'b1, 4'd0,  32'hFFFF_FFFF, 32'h0},
    '{1'b1, 4'd4,  32'h1111_1111, 32'h0},
    '{1'b1, 4'd4,  32'h2222_2222, 32'h0},
    '{1'b0, 4'd3,  32'h0, 32'd30},         // R2 vacancy
    '{1'b1, 4'd5,  32'd9, 32'h0},          // R5 mismatch
    '{1'b0, 4'd0,  32'h0, 32'h0200_0000},  // R5
    '{1'b0, 4'd3,  32'h0, 32'd32},         // R5 words dropped
    '{1'b1, 4'd5,  32'd0, 32'h0},          // R5 zero length
    '{1'b0, 4'd0,  32'h0, 32'h0200_0000},  // R5
    '{1'b1, 4'd0,  32'hFFFF_FFFF, 32'h0},
    '{1'b0, 4'd3,  32'h0, 32'd32}          // R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    regWordAddr = idx; regWdata = d; regWr = 1'b1;
    @(posedge clk); #1 regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    regWordAddr = idx; regRd = 1'b1;
    #1 d = regRdata;
    @(posedge clk); #1 regRd = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [3:0] idx, input logic [31:0] exp);
    logic [31:0] d;
    rdReg(idx, d);
    chk(tag, d, exp);
  endtask

  task automatic rxPut(input logic [31:0] d, input logic last, input logic [3:0] keep);
    @(negedge clk);
    rxValid = 1'b1; rxData = d; rxLast = last; rxKeep = keep;
    @(posedge clk); #1 rxValid = 1'b0; rxLast = 1'b0;
  endtask

  function automatic logic [3:0] expKeep(input int len);
    case (len % 4)
      1: return 4'b0001;
      2: return 4'b0011;
      3: return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  // R3 R4 R12: send one packet of len bytes and watch it leave
  task automatic txPacket(input int len, input logic [31:0] base, input bit holdFirst);
    int words;
    words = (len + 3) / 4;
    for (int i = 0; i < words; i++) wrReg(4'd4, base + i);
    rdChk("R2 vacancy after pushes", 4'd3, 32 - words);
    wrReg(4'd5, len);
    @(negedge clk);
    chk("R3 txValid after commit", {31'd0, txValid}, 32'd1);
    if (holdFirst) begin
      repeat (3) @(negedge clk);
      chk("R12 data held", txData, base);
      chk("R12 valid held", {31'd0, txValid}, 32'd1);
    end
    for (int i = 0; i < words; i++) begin
      if (i > 0) @(negedge clk);
      txReady = 1'b1;
      chk("R3 valid", {31'd0, txValid}, 32'd1);
      chk("R3 data order", txData, base + i);
      chk("R3 last flag", {31'd0, txLast}, {31'd0, (i == words - 1)});
      chk("R3 keep", {28'd0, txKeep}, {28'd0, (i == words - 1) ? expKeep(len) : 4'b1111});
    end
    @(negedge clk);
    txReady = 1'b0;
    chk("R3 valid drops", {31'd0, txValid}, 32'd0);
    rdChk("R4 tx complete", 4'd0, 32'h0800_0000);
    rdChk("R2 vacancy restored", 4'd3, 32'd32);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 txValid", {31'd0, txValid}, 32'd0);
    chk("R1 rxReady", {31'd0, rxReady}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isWr) wrReg(VECS[i].idx, VECS[i].data);
      else begin
        rdReg(VECS[i].idx, d);
        chk($sformatf("vector %0d", i), d, VECS[i].exp);
      end
    end
    @(negedge clk);
    chk("R5 nothing sent", {31'd0, txValid}, 32'd0);

    // R11 irq via enable of TX complete
    wrReg(4'd1, 32'h0800_0000);
    txPacket(10, 32'hA000_0000, 1'b1);
    @(negedge clk);
    chk("R11 irq high", {31'd0, irq}, 32'd1);
    wrReg(4'd0, 32'h0800_0000);
    @(negedge clk);
    chk("R11 irq cleared", {31'd0, irq}, 32'd0);
    txPacket(5, 32'hB000_0000, 1'b0);
    wrReg(4'd0, 32'hFFFF_FFFF);
    txPacket(7, 32'hC000_0000, 1'b0);
    wrReg(4'd0, 32'hFFFF_FFFF);
    txPacket(8, 32'hD000_0000, 1'b0);
    wrReg(4'd0, 32'hFFFF_FFFF);
    wrReg(4'd1, 32'h0);

    // R6 R7 R8 receive
    rxPut(32'hE000_0000, 1'b0, 4'b1111);
    rxPut(32'hE000_0001, 1'b0, 4'b1111);
    rxPut(32'hE000_0002, 1'b1, 4'b0011);
    rxPut(32'hF000_0000, 1'b1, 4'b1111);
    rxPut(32'h9000_0000, 1'b1, 4'b0001);
    rdChk("R7 occupancy", 4'd7, 32'd5);
    rdChk("R6 rx complete", 4'd0, 32'h0400_0000);
    rdChk("R8 first length", 4'd9, 32'd10);
    rdChk("R8 word 0", 4'd8, 32'hE000_0000);
    rdChk("R8 word 1", 4'd8, 32'hE000_0001);
    rdChk("R8 word 2", 4'd8, 32'hE000_0002);
    rdChk("R8 second length", 4'd9, 32'd4);
    rdChk("R8 word B", 4'd8, 32'hF000_0000);
    rdChk("R6 single-byte length", 4'd9, 32'd1);
    rdChk("R8 word C", 4'd8, 32'h9000_0000);
    rdChk("R7 occupancy empty", 4'd7, 32'd0);
    wrReg(4'd0, 32'hFFFF_FFFF);

    // R13 rx fill
    for (int i = 0; i < 32; i++) rxPut(32'h5500_0000 + i, 1'b0, 4'b1111);
    @(negedge clk);
    chk("R13 rxReady low when full", {31'd0, rxReady}, 32'd0);
    rdChk("R13 occupancy at depth", 4'd7, 32'd32);
    wrReg(4'd6, 32'hA5);
    rdChk("R10 rx cleared", 4'd7, 32'd0);
    rdChk("R10 rx reset done", 4'd0, 32'h0080_0000);
    @(negedge clk);
    chk("R10 rxReady back", {31'd0, rxReady}, 32'd1);
    wrReg(4'd0, 32'hFFFF_FFFF);

    // R2 tx overrun, then R10 link reset
    for (int i = 0; i < 33; i++) wrReg(4'd4, i);
    rdChk("R2 vacancy zero", 4'd3, 32'd0);
    rdChk("R2 overrun bit", 4'd0, 32'h1000_0000);
    wrReg(4'd10, 32'h1A5);
    rdChk("R10 link wrong key", 4'd3, 32'd0);
    wrReg(4'd10, 32'hA5);
    rdChk("R10 link vacancy", 4'd3, 32'd32);
    rdChk("R10 link status", 4'd0, 32'h1180_0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule